// File: doc/BRIEF.md
# Pattern-Sequence Memory Self-Test Controller

This block is a built-in self-test engine for a synchronous single-port RAM of 2^ADDR_W words of DATA_W bits (by default 8192 x 16). Once a run is launched it takes over the RAM strobes and walks a fixed four-phase march. The first two phases fill the array with a background value, all zeros and then all ones. Each cell is then visited in ascending order: the controller checks the background, writes and reads back eight stripe patterns, and restores the background. The third phase stores every cell's own address as data and sweeps it back. The fourth phase does the same with the bitwise inverse of the address.

Software reaches the block through one 16-bit control register. It holds an enable bit, a 3-bit mode select, a start bit and a 2-bit result. The start bit can be set only while the external test-mode pin is high and the enable bit was already 1 before the write. The start bit clears itself when the run ends. The first mismatch stops the run and keeps the failing address and the expected word for debug.

States: IDLE, FILL (background write sweep), CELL_RD and CELL_CMP (read, then compare one cycle later), CELL_WR (write the next pattern), RESTORE (write the background back and advance), ADDR_WR (address or inverted-address write sweep), SWEEP_RD and SWEEP_CMP (read-back sweep). Transitions:
- IDLE goes to FILL on launch.
- FILL goes to CELL_RD after the last address.
- CELL_RD goes to CELL_CMP.
- CELL_CMP goes to CELL_WR while patterns remain, to RESTORE after the eighth pattern, and to IDLE on a mismatch.
- CELL_WR goes to CELL_RD.
- RESTORE goes to CELL_RD for the next cell. After the last cell it goes to FILL (background phase 1) or to ADDR_WR (background phase 2).
- ADDR_WR goes to SWEEP_RD after the last address.
- SWEEP_RD goes to SWEEP_CMP.
- SWEEP_CMP goes to SWEEP_RD for the next address, to ADDR_WR after the address phase, and to IDLE after the inverted phase or on a mismatch.

Top module: `pattern_bist_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000, and neither RAM strobe is active.
- R2: Control register layout: bit 15 is enable, bits 13:11 are the mode select, bit 10 is start and bits 9:8 are the result. Enable and mode are written directly. Bit 14 and bits 7:0 read as 0, and a write does not change the result field.
- R3: A write of 1 to start takes effect only if the test-mode pin is high and enable was already 1 before that write. Otherwise start stays 0 and no RAM access happens.
- R4: If start is set while the mode is not 3'b001, no RAM access happens, start clears on the next cycle and the result stays 2'b00.
- R5: The background phases run in order. Phase 1 fills the array with 0x0000 and phase 2 with 0xFFFF. For each cell in ascending address order, a phase reads the background, writes and reads back each pattern, and then rewrites the background. A full passing run makes exactly 22·N writes and 20·N reads, where N is the depth.
- R6: The per-cell pattern order is 0x5555, 0xAAAA, 0x3333, 0xCCCC, 0x0F0F, 0xF0F0, 0x00FF, 0xFF00.
- R7: Phase 3 writes each address zero-extended as data, then reads every address back in ascending order. Phase 4 does the same with the 16-bit bitwise inverse of that value.
- R8: The result reads 2'b00 while a run is in progress. When a run passes, start clears and the result becomes 2'b01.
- R9: On the first mismatch the run stops. Start clears, the result becomes 2'b10, and fail_addr and fail_expect hold the cell address and the expected word. No further RAM access follows.
- R10: The RAM is read with one cycle of latency. Each compare uses the data returned for the read issued in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_mode_i | input | 1 | External test-mode pin that gates start |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 16 | Control register write data |
| ctl_rd_data | output | 16 | Control register contents |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_rd_en | output | 1 | RAM read strobe |
| ram_rdata | input | DATA_W | RAM read data, valid the cycle after ram_rd_en |
| fail_addr | output | ADDR_W | Address of the first mismatching cell |
| fail_expect | output | DATA_W | Word expected at that cell |

## Verification
The hardest outcome to bring about from the ports is a failure in one chosen phase and one chosen pattern step, because every earlier step must still pass. The bench's behavioural RAM injects four faults for this:
- A stuck-at-1 bit, which trips the first background check.
- A stuck-at-0 bit, which passes 0x5555 but fails 0xAAAA and so pins down the pattern order.
- A write alias that the background phases hide by restoring both cells, and that only the address phase exposes.
- A data-sensitive fault that triggers only on the inverted address word.
The bench runs with a 64-word array so that full passing runs fit in the cycle budget.

// File: rtl/bist_pkg.sv
package bist_pkg;
    localparam int CTL_W     = 16;
    localparam int EN_BIT    = 15;
    localparam int MODE_LSB  = 11;
    localparam int MODE_W    = 3;
    localparam int START_BIT = 10;
    localparam int RES_LSB   = 8;

    localparam logic [MODE_W-1:0] MODE_PATTERN = 3'b001;

    typedef enum logic [1:0] {
        RES_NONE = 2'b00,
        RES_PASS = 2'b01,
        RES_FAIL = 2'b10
    } result_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FILL,
        S_CELL_RD,
        S_CELL_CMP,
        S_CELL_WR,
        S_RESTORE,
        S_ADDR_WR,
        S_SWEEP_RD,
        S_SWEEP_CMP
    } state_e;
endpackage

// File: rtl/bist_ctrl_reg.sv
module bist_ctrl_reg
    import bist_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_pin,
    input  logic              wr_en,
    input  logic [CTL_W-1:0]  wr_data,
    input  logic              done,
    input  result_e           done_code,
    output logic [CTL_W-1:0]  rd_data,
    output logic              start_q,
    output logic [MODE_W-1:0] mode_q
);
    logic    en_q;
    result_e res_q;
    logic    start_set;
    logic    unused_bits;

    assign unused_bits = ^{wr_data[14], wr_data[9:0]};
    assign start_set   = wr_en && wr_data[START_BIT] && test_pin && en_q && !start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            mode_q  <= '0;
            start_q <= 1'b0;
            res_q   <= RES_NONE;
        end else begin
            if (wr_en) begin
                en_q   <= wr_data[EN_BIT];
                mode_q <= wr_data[MODE_LSB +: MODE_W];
            end
            if (start_set) begin
                start_q <= 1'b1;
                res_q   <= RES_NONE;
            end else if (done) begin
                start_q <= 1'b0;
                res_q   <= done_code;
            end
        end
    end

    always_comb begin
        rd_data                        = '0;
        rd_data[EN_BIT]                = en_q;
        rd_data[MODE_LSB +: MODE_W]    = mode_q;
        rd_data[START_BIT]             = start_q;
        rd_data[RES_LSB +: 2]          = res_q;
    end

    // R3
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_q) |-> ($past(test_pin) && $past(en_q)));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_q) |-> ($fell(start_q) || $rose(start_q)));
endmodule

// File: rtl/bist_data_gen.sv
module bist_data_gen #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 16,
    parameter int STEP_W = 4
) (
    input  logic [1:0]        phase,
    input  logic [STEP_W-1:0] step,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int NUM_STRIPES = $clog2(DATA_W);
    localparam int SIDX_W      = $clog2(NUM_STRIPES);

    logic [NUM_STRIPES-1:0][DATA_W-1:0] stripe;
    logic [STEP_W-1:0]                  idx;
    logic [DATA_W-1:0]                  pat;
    logic [DATA_W-1:0]                  addr_word;

    for (genvar k = 0; k < NUM_STRIPES; k++) begin : g_stripe
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            assign stripe[k][b] = (((b >> k) % 2) == 0) ? 1'b1 : 1'b0;
        end
    end

    assign idx       = step - 1'b1;
    assign pat       = stripe[idx[SIDX_W:1]] ^ {DATA_W{idx[0]}};
    assign addr_word = DATA_W'(addr);

    always_comb begin
        unique case (phase)
            2'd0:    data = (step == '0) ? '0 : pat;
            2'd1:    data = (step == '0) ? '1 : pat;
            2'd2:    data = addr_word;
            default: data = ~addr_word;
        endcase
    end
endmodule

// File: rtl/bist_march_fsm.sv
module bist_march_fsm
    import bist_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 16,
    parameter int STEP_W    = 4,
    parameter int LAST_STEP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_req,
    input  logic [MODE_W-1:0] mode,
    input  logic [DATA_W-1:0] cell_data,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [1:0]        phase,
    output logic [STEP_W-1:0] step,
    output logic [ADDR_W-1:0] addr,
    output logic              ram_wr_en,
    output logic              ram_rd_en,
    output logic              done,
    output result_e           done_code,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_expect
);
    state_e st, st_nx;
    logic   last_addr;
    logic   mismatch;
    logic   last_step;
    logic   in_cmp;

    assign last_addr = &addr;
    assign mismatch  = (ram_rdata != cell_data);
    assign last_step = (step == STEP_W'(LAST_STEP));
    assign in_cmp    = (st == S_CELL_CMP) || (st == S_SWEEP_CMP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx     = st;
        done      = 1'b0;
        done_code = RES_NONE;
        unique case (st)
            S_IDLE: begin
                if (run_req) begin
                    if (mode == MODE_PATTERN) st_nx = S_FILL;
                    else                      done  = 1'b1;
                end
            end
            S_FILL:     if (last_addr) st_nx = S_CELL_RD;
            S_CELL_RD:  st_nx = S_CELL_CMP;
            S_CELL_CMP: begin
                if (mismatch) begin
                    st_nx     = S_IDLE;
                    done      = 1'b1;
                    done_code = RES_FAIL;
                end else if (last_step) st_nx = S_RESTORE;
                else                    st_nx = S_CELL_WR;
            end
            S_CELL_WR:  st_nx = S_CELL_RD;
            S_RESTORE: begin
                if (last_addr) st_nx = (phase == 2'd0) ? S_FILL : S_ADDR_WR;
                else           st_nx = S_CELL_RD;
            end
            S_ADDR_WR:  if (last_addr) st_nx = S_SWEEP_RD;
            S_SWEEP_RD: st_nx = S_SWEEP_CMP;
            S_SWEEP_CMP: begin
                if (mismatch) begin
                    st_nx     = S_IDLE;
                    done      = 1'b1;
                    done_code = RES_FAIL;
                end else if (last_addr) begin
                    if (phase == 2'd2) st_nx = S_ADDR_WR;
                    else begin
                        st_nx     = S_IDLE;
                        done      = 1'b1;
                        done_code = RES_PASS;
                    end
                end else st_nx = S_SWEEP_RD;
            end
            default: st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase       <= '0;
            step        <= '0;
            addr        <= '0;
            fail_addr   <= '0;
            fail_expect <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (run_req && mode == MODE_PATTERN) begin
                        phase       <= '0;
                        step        <= '0;
                        addr        <= '0;
                        fail_addr   <= '0;
                        fail_expect <= '0;
                    end
                end
                S_FILL, S_ADDR_WR: addr <= addr + 1'b1;
                S_CELL_CMP: begin
                    if (mismatch) begin
                        fail_addr   <= addr;
                        fail_expect <= cell_data;
                    end else if (last_step) step <= '0;
                    else                    step <= step + 1'b1;
                end
                S_RESTORE: begin
                    addr <= addr + 1'b1;
                    if (last_addr) phase <= phase + 2'd1;
                end
                S_SWEEP_CMP: begin
                    if (mismatch) begin
                        fail_addr   <= addr;
                        fail_expect <= cell_data;
                    end else begin
                        addr <= addr + 1'b1;
                        if (last_addr) phase <= phase + 2'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        ram_wr_en = (st == S_FILL) || (st == S_CELL_WR) || (st == S_RESTORE) || (st == S_ADDR_WR);
        ram_rd_en = (st == S_CELL_RD) || (st == S_SWEEP_RD);
    end

    // R10
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_cmp |-> $past(ram_rd_en));

    // R9
    fail_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cmp && mismatch) |=> (st == S_IDLE && !ram_wr_en && !ram_rd_en));

    // R4
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE) |-> run_req);

    // R7
    sweep_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SWEEP_RD && $past(st) == S_SWEEP_CMP) |-> (addr == ADDR_W'($past(addr) + 1'b1)));
endmodule

// File: rtl/pattern_bist_ctrl.sv
module pattern_bist_ctrl
    import bist_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_mode_i,
    input  logic              ctl_wr_en,
    input  logic [15:0]       ctl_wr_data,
    output logic [15:0]       ctl_rd_data,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_wr_en,
    output logic              ram_rd_en,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_expect
);
    localparam int NUM_STEPS = 2 * $clog2(DATA_W);
    localparam int STEP_W    = $clog2(NUM_STEPS + 1);

    logic              start_q;
    logic [MODE_W-1:0] mode_q;
    logic              done;
    result_e           done_code;
    logic [1:0]        phase;
    logic [STEP_W-1:0] step;
    logic [DATA_W-1:0] cell_data;

    bist_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_pin  (test_mode_i),
        .wr_en     (ctl_wr_en),
        .wr_data   (ctl_wr_data),
        .done      (done),
        .done_code (done_code),
        .rd_data   (ctl_rd_data),
        .start_q   (start_q),
        .mode_q    (mode_q)
    );

    bist_data_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W)) u_gen (
        .phase (phase),
        .step  (step),
        .addr  (ram_addr),
        .data  (cell_data)
    );

    bist_march_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W), .LAST_STEP(NUM_STEPS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_req     (start_q),
        .mode        (mode_q),
        .cell_data   (cell_data),
        .ram_rdata   (ram_rdata),
        .phase       (phase),
        .step        (step),
        .addr        (ram_addr),
        .ram_wr_en   (ram_wr_en),
        .ram_rd_en   (ram_rd_en),
        .done        (done),
        .done_code   (done_code),
        .fail_addr   (fail_addr),
        .fail_expect (fail_expect)
    );

    assign ram_wdata = cell_data;
endmodule

// File: tb/pattern_bist_ctrl_tb_top.sv
module pattern_bist_ctrl_tb_top;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int N  = 1 << AW;

    typedef struct {
        string       req;
        string       tag;
        logic [1:0]  res;
        bit          chk_fail;
        logic [5:0]  faddr;
        logic [15:0] fexp;
        bit          chk_cnt;
        int          wr;
        int          rd;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          test_mode_i;
    logic          ctl_wr_en;
    logic [15:0]   ctl_wr_data;
    logic [15:0]   ctl_rd_data;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic          ram_wr_en;
    logic          ram_rd_en;
    logic [DW-1:0] ram_rdata;
    logic [AW-1:0] fail_addr;
    logic [DW-1:0] fail_expect;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int fault_kind = 0;   // 0 none, 1 stuck-1, 2 stuck-0, 3 alias 35->3, 4 data-sensitive at 7
    logic [AW-1:0] f_addr = '0;
    int f_bit = 0;
    exp_t exp_q[$];

    logic [DW-1:0] mem [N];

    always #4 clk = ~clk;

    pattern_bist_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .test_mode_i(test_mode_i),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_wr_en(ram_wr_en),
        .ram_rd_en(ram_rd_en), .ram_rdata(ram_rdata),
        .fail_addr(fail_addr), .fail_expect(fail_expect)
    );

    function automatic logic [DW-1:0] read_cell(logic [AW-1:0] a);
        logic [DW-1:0] v;
        v = mem[a];
        if (fault_kind == 1 && a == f_addr) v = v | (DW'(1) << f_bit);
        if (fault_kind == 2 && a == f_addr) v = v & ~(DW'(1) << f_bit);
        if (fault_kind == 4 && a == AW'(7) && v == 16'hFFF8) v = v & ~16'h4000;
        return v;
    endfunction

    always @(posedge clk) begin
        if (ram_wr_en) begin
            mem[ram_addr] <= ram_wdata;
            if (fault_kind == 3 && ram_addr == AW'(35)) mem[3] <= ram_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (ram_rd_en) begin
            ram_rdata <= read_cell(ram_addr);
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic reg_write(logic [15:0] v);
        @(negedge clk);
        ctl_wr_en   = 1'b1;
        ctl_wr_data = v;
        @(negedge clk);
        ctl_wr_en   = 1'b0;
    endtask

    task automatic run_case(exp_t e, logic [15:0] ctl);
        wr_cnt = 0;
        rd_cnt = 0;
        reg_write(ctl);
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    // monitor / scoreboard
    initial begin
        exp_t e;
        int w0;
        int r0;
        forever begin
            wait (exp_q.size() > 0);
            e = exp_q[0];
            chk(ctl_rd_data[10] == 1'b1 && ctl_rd_data[9:8] == 2'b00, "R8",
                {e.tag, " start set, result clear at launch"},
                32'(ctl_rd_data[10:8]), 32'h4);
            while (ctl_rd_data[10]) @(negedge clk);
            chk(ctl_rd_data[9:8] == e.res, e.req, {e.tag, " result"},
                32'(ctl_rd_data[9:8]), 32'(e.res));
            if (e.chk_fail) begin
                chk(fail_addr == e.faddr, e.req, {e.tag, " fail_addr"}, 32'(fail_addr), 32'(e.faddr));
                chk(fail_expect == e.fexp, e.req, {e.tag, " fail_expect"}, 32'(fail_expect), 32'(e.fexp));
            end
            if (e.chk_cnt) begin
                chk(wr_cnt == e.wr, e.req, {e.tag, " write count"}, 32'(wr_cnt), 32'(e.wr));
                chk(rd_cnt == e.rd, e.req, {e.tag, " read count"}, 32'(rd_cnt), 32'(e.rd));
            end
            w0 = wr_cnt;
            r0 = rd_cnt;
            repeat (20) @(negedge clk);
            chk(wr_cnt == w0 && rd_cnt == r0, "R9", {e.tag, " RAM quiet after finish"},
                32'(wr_cnt + rd_cnt), 32'(w0 + r0));
            void'(exp_q.pop_front());
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual %0d expected %0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        exp_t e;
        rst_n       = 1'b0;
        test_mode_i = 1'b0;
        ctl_wr_en   = 1'b0;
        ctl_wr_data = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1
        chk(ctl_rd_data == 16'h0000, "R1", "register after reset", 32'(ctl_rd_data), 32'h0);
        chk(!ram_wr_en && !ram_rd_en, "R1", "RAM strobes in reset",
            32'({ram_wr_en, ram_rd_en}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R3: enable not yet set, so start must not take
        test_mode_i = 1'b1;
        reg_write(16'hFFFF);
        chk(ctl_rd_data == 16'hB800, "R2", "layout readback", 32'(ctl_rd_data), 32'hB800);
        chk(ctl_rd_data[10] == 1'b0, "R3", "start ignored without prior enable",
            32'(ctl_rd_data[10]), 32'h0);

        // R3: pin low blocks start
        test_mode_i = 1'b0;
        reg_write(16'h8800);
        wr_cnt = 0;
        rd_cnt = 0;
        reg_write(16'h8C00);
        repeat (3) @(negedge clk);
        chk(ctl_rd_data == 16'h8800, "R3", "start ignored with pin low", 32'(ctl_rd_data), 32'h8800);
        chk(wr_cnt == 0 && rd_cnt == 0, "R3", "no RAM access with pin low",
            32'(wr_cnt + rd_cnt), 32'h0);
        test_mode_i = 1'b1;

        // R5 R7 R8 R10: full passing run
        e = '{req:"R5", tag:"pass run", res:2'b01, chk_fail:0, faddr:'0, fexp:'0,
              chk_cnt:1, wr:22*N, rd:20*N};
        run_case(e, 16'h8C00);

        // R4: wrong mode
        e = '{req:"R4", tag:"mode 010", res:2'b00, chk_fail:0, faddr:'0, fexp:'0,
              chk_cnt:1, wr:0, rd:0};
        run_case(e, 16'h9400);

        // R9 R5: stuck-at-1 bit 0 at cell 5 trips the zero background check
        fault_kind = 1; f_addr = AW'(5); f_bit = 0;
        e = '{req:"R9", tag:"stuck1 bg", res:2'b10, chk_fail:1, faddr:6'd5, fexp:16'h0000,
              chk_cnt:0, wr:0, rd:0};
        run_case(e, 16'h8C00);

        // R6: stuck-at-0 bit 3 at cell 9 passes 0x5555, fails 0xAAAA
        fault_kind = 2; f_addr = AW'(9); f_bit = 3;
        e = '{req:"R6", tag:"stuck0 order", res:2'b10, chk_fail:1, faddr:6'd9, fexp:16'hAAAA,
              chk_cnt:0, wr:0, rd:0};
        run_case(e, 16'h8C00);

        // R7: write alias 35 -> 3 exposed only by address-in-data
        fault_kind = 3;
        e = '{req:"R7", tag:"alias addr", res:2'b10, chk_fail:1, faddr:6'd3, fexp:16'h0003,
              chk_cnt:0, wr:0, rd:0};
        run_case(e, 16'h8C00);

        // R7: data-sensitive fault on inverted address of cell 7
        fault_kind = 4;
        e = '{req:"R7", tag:"inverted addr", res:2'b10, chk_fail:1, faddr:6'd7, fexp:16'hFFF8,
              chk_cnt:0, wr:0, rd:0};
        run_case(e, 16'h8C00);

        // R8: rerun after a failure clears result and passes
        fault_kind = 0;
        e = '{req:"R8", tag:"rerun pass", res:2'b01, chk_fail:0, faddr:'0, fexp:'0,
              chk_cnt:1, wr:22*N, rd:20*N};
        run_case(e, 16'h8C00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule